// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block forms the word address for a single-word memory load or store. It also forms the value that goes back into the base register when the addressing form updates it. A request carries a base value and an offset. The offset is either a 12-bit unsigned immediate or an index value passed through a barrel shifter. A direction bit chooses whether the offset is added or subtracted. A two-bit indexing mode controls how the address and the base update relate to each other.

When the base is the program counter, the unit sees it eight bytes ahead of the instruction address. Each request reaches a small synchronous word memory in the same clock edge. One clock after the request the unit returns four things together:
- the registered address,
- the base-update strobe and its value,
- a valid pulse,
- for a load, the word that was read.

All arithmetic wraps modulo 2^32 and never faults. The two lowest address bits are ignored when selecting a memory word.

Top module: `ldst_agu`

## Requirements
- R1: While reset is asserted and after it is released, with no request, `valid` and `wb_en` are 0.
- R2: `valid` is 1 in exactly the cycle after each cycle in which `req` is 1, and 0 otherwise.
- R3: With `mode` 2'b00 or 2'b11 the address is base plus or minus offset and `wb_en` stays 0.
- R4: With `mode` 2'b01 the address is base plus or minus offset, `wb_en` is 1 and `wb_val` equals that same address.
- R5: With `mode` 2'b10 the address is the unmodified base, `wb_en` is 1 and `wb_val` is base plus or minus offset.
- R6: With `use_reg` 0 the offset is `imm_off` zero-extended to 32 bits. `up` 1 adds it and `up` 0 subtracts it.
- R7: With `use_reg` 1 the offset is `idx_val` shifted by `shift_amt`. `shift_kind` 0 is a logical left shift, 1 a logical right shift, 2 an arithmetic right shift and 3 a right rotate. An amount of 0 leaves the value unchanged.
- R8: With `base_is_pc` 1 the base used for both the address and the update is `base_val` + 8.
- R9: Address and update arithmetic wrap modulo 2^32.
- R10: A store writes `st_data` to word `addr[9:2]` at the request edge. A load returns that word on `rd_data` together with `valid`.
- R11: `wb_en` is never 1 without `valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, one access per cycle |
| is_store | input | 1 | 1 store, 0 load |
| base_is_pc | input | 1 | Base register is the program counter |
| base_val | input | 32 | Base register value |
| use_reg | input | 1 | 1 selects the shifted index, 0 the immediate |
| imm_off | input | 12 | Unsigned immediate offset |
| idx_val | input | 32 | Index register value |
| shift_kind | input | 2 | 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| shift_amt | input | 5 | Shift amount |
| up | input | 1 | 1 add offset, 0 subtract |
| mode | input | 2 | 00 offset, 01 pre-update, 10 post-update, 11 as 00 |
| st_data | input | 32 | Store data |
| addr | output | 32 | Registered effective address |
| wb_en | output | 1 | Base update strobe |
| wb_val | output | 32 | New base value |
| valid | output | 1 | Result strobe, one cycle after `req` |
| rd_data | output | 32 | Load data |

## Verification
The assertions check the following on every cycle:
- the one-cycle relation between request and valid;
- that the update strobe never appears without valid;
- that the offset forms never update the base;
- that pre-update returns the address as the new base;
- that post-update issues the unmodified base;
- that a zero shift leaves the index untouched.

Only the bench's scenarios can show the following, because each needs expected numbers:
- the actual sums and differences;
- each shift kind with sign fill and rotation;
- the eight-byte program-counter view;
- wraparound at both ends of the address space;
- store-then-load round trips through the memory.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int WORD_W   = 32;
  localparam int IMM_W    = 12;
  localparam int AMT_W    = 5;
  localparam int PC_AHEAD = 8;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    IDX_OFFSET = 2'b00,
    IDX_PRE    = 2'b01,
    IDX_POST   = 2'b10,
    IDX_RSVD   = 2'b11
  } idx_mode_e;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_e;

  // Base as seen by the address path: the program counter reads ahead.
  function automatic word_t pc_view(word_t b, logic is_pc);
    return is_pc ? b + word_t'(PC_AHEAD) : b;
  endfunction

  // Signed application of a magnitude offset; wraps modulo 2^WORD_W.
  function automatic word_t apply_off(word_t b, word_t o, logic up);
    return up ? b + o : b - o;
  endfunction

  function automatic logic mode_updates(idx_mode_e m);
    return (m == IDX_PRE) || (m == IDX_POST);
  endfunction

  function automatic logic mode_post(idx_mode_e m);
    return m == IDX_POST;
  endfunction
endpackage

// File: rtl/agu_shifter.sv
module agu_shifter
  import agu_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int AW = AMT_W
) (
  input  logic [W-1:0]  val,
  input  shift_e        kind,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  res
);
  // Logarithmic barrel shifter: stage s moves by 2^s when amt[s] is set.
  logic [AW:0][W-1:0] stg;
  assign stg[0] = val;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int N = 1 << s;
    logic [W-1:0] moved;
    always_comb begin
      unique case (kind)
        SH_LSL:  moved = stg[s] << N;
        SH_LSR:  moved = stg[s] >> N;
        SH_ASR:  moved = W'($signed(stg[s]) >>> N);
        default: moved = (stg[s] >> N) | (stg[s] << (W - N));
      endcase
    end
    assign stg[s+1] = amt[s] ? moved : stg[s];
  end

  assign res = stg[AW];
endmodule

// File: rtl/agu_addr.sv
module agu_addr
  import agu_pkg::*;
(
  input  word_t     base_val,
  input  logic      base_is_pc,
  input  word_t     offset,
  input  logic      up,
  input  idx_mode_e mode,
  output word_t     base_eff,
  output word_t     access_addr,
  output word_t     wb_next,
  output logic      wb_want
);
  word_t moved_base;

  assign base_eff    = pc_view(base_val, base_is_pc);
  assign moved_base  = apply_off(base_eff, offset, up);
  // Post-update issues the old base; every other mode issues the moved one.
  assign access_addr = mode_post(mode) ? base_eff : moved_base;
  assign wb_next     = moved_base;
  assign wb_want     = mode_updates(mode);
endmodule

// File: rtl/agu_mem.sv
module agu_mem
  import agu_pkg::*;
#(
  parameter int WORDS = 256,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [IW-1:0] idx,
  input  word_t         wdata,
  output word_t         rdata
);
  word_t store_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) store_q[idx] <= wdata;
    if (re) rdata <= store_q[idx];
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import agu_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int IW       = $clog2(MEM_WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic                is_store,
  input  logic                base_is_pc,
  input  logic [WORD_W-1:0]   base_val,
  input  logic                use_reg,
  input  logic [IMM_W-1:0]    imm_off,
  input  logic [WORD_W-1:0]   idx_val,
  input  logic [1:0]          shift_kind,
  input  logic [AMT_W-1:0]    shift_amt,
  input  logic                up,
  input  logic [1:0]          mode,
  input  logic [WORD_W-1:0]   st_data,
  output logic [WORD_W-1:0]   addr,
  output logic                wb_en,
  output logic [WORD_W-1:0]   wb_val,
  output logic                valid,
  output logic [WORD_W-1:0]   rd_data
);
  // Named internal events, visible to the bound checker.
  word_t off_shifted;
  word_t offset_val;
  word_t base_eff;
  word_t access_addr;
  word_t wb_next;
  logic  wb_want;
  logic  mem_we;
  logic  mem_re;

  agu_shifter #(.W(WORD_W), .AW(AMT_W)) u_shift (
    .val  (idx_val),
    .kind (shift_e'(shift_kind)),
    .amt  (shift_amt),
    .res  (off_shifted)
  );

  assign offset_val = use_reg ? off_shifted
                              : {{(WORD_W-IMM_W){1'b0}}, imm_off};

  agu_addr u_addr (
    .base_val    (base_val),
    .base_is_pc  (base_is_pc),
    .offset      (offset_val),
    .up          (up),
    .mode        (idx_mode_e'(mode)),
    .base_eff    (base_eff),
    .access_addr (access_addr),
    .wb_next     (wb_next),
    .wb_want     (wb_want)
  );

  assign mem_we = req &&  is_store;
  assign mem_re = req && !is_store;

  agu_mem #(.WORDS(MEM_WORDS)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .idx   (access_addr[IW+1:2]),
    .wdata (st_data),
    .rdata (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      wb_en  <= 1'b0;
      addr   <= '0;
      wb_val <= '0;
    end else begin
      valid <= req;
      wb_en <= req && wb_want;
      if (req) begin
        addr   <= access_addr;
        wb_val <= wb_next;
      end
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [1:0]        mode,
  input logic              use_reg,
  input logic [AMT_W-1:0]  shift_amt,
  input logic [WORD_W-1:0] idx_val,
  input logic [WORD_W-1:0] off_shifted,
  input logic [WORD_W-1:0] base_eff,
  input logic [WORD_W-1:0] addr,
  input logic              wb_en,
  input logic [WORD_W-1:0] wb_val,
  input logic              valid
);
  // Set once a full clock has passed outside reset, so that $past is meaningful.
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_valid_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (valid == $past(req)));

  assert_wb_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> valid);

  assert_offset_no_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && valid && ($past(mode) == 2'b00 || $past(mode) == 2'b11)) |-> !wb_en);

  assert_pre_update_is_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && valid && $past(mode) == 2'b01) |-> (wb_en && wb_val == addr));

  assert_post_uses_old_base_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && valid && $past(mode) == 2'b10) |-> (wb_en && addr == $past(base_eff)));

  assert_zero_shift_passes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (use_reg && shift_amt == '0) |-> (off_shifted == idx_val));
endmodule

bind ldst_agu agu_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req         (req),
  .mode        (mode),
  .use_reg     (use_reg),
  .shift_amt   (shift_amt),
  .idx_val     (idx_val),
  .off_shifted (off_shifted),
  .base_eff    (base_eff),
  .addr        (addr),
  .wb_en       (wb_en),
  .wb_val      (wb_val),
  .valid       (valid)
);

// File: tb/ldst_agu_tb.sv
module ldst_agu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, is_store = 1'b0, base_is_pc = 1'b0, use_reg = 1'b0, up = 1'b1;
  logic [31:0] base_val = '0, idx_val = '0, st_data = '0;
  logic [11:0] imm_off = '0;
  logic [1:0]  shift_kind = '0, mode = '0;
  logic [4:0]  shift_amt = '0;
  logic [31:0] addr, wb_val, rd_data;
  logic        wb_en, valid;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ldst_agu u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .is_store(is_store),
    .base_is_pc(base_is_pc), .base_val(base_val), .use_reg(use_reg),
    .imm_off(imm_off), .idx_val(idx_val), .shift_kind(shift_kind),
    .shift_amt(shift_amt), .up(up), .mode(mode), .st_data(st_data),
    .addr(addr), .wb_en(wb_en), .wb_val(wb_val), .valid(valid),
    .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Reference shifter, one bit position per step.
  function automatic logic [31:0] ref_shift(logic [31:0] v, logic [1:0] k, logic [4:0] a);
    logic [31:0] r = v;
    for (int i = 0; i < int'(a); i++) begin
      case (k)
        2'd0: r = {r[30:0], 1'b0};
        2'd1: r = {1'b0, r[31:1]};
        2'd2: r = {r[31], r[31:1]};
        default: r = {r[0], r[31:1]};
      endcase
    end
    return r;
  endfunction

  // Issue one request and return after the result has settled.
  task automatic issue(input logic [1:0] md, input logic pc, input logic [31:0] b,
                       input logic ur, input logic [11:0] imm, input logic [31:0] ix,
                       input logic [1:0] k, input logic [4:0] a, input logic u,
                       input logic st, input logic [31:0] wd);
    @(negedge clk);
    mode = md; base_is_pc = pc; base_val = b; use_reg = ur; imm_off = imm;
    idx_val = ix; shift_kind = k; shift_amt = a; up = u; is_store = st;
    st_data = wd; req = 1'b1;
    @(negedge clk);
    req = 1'b0; is_store = 1'b0;
  endtask

  task automatic expect_result(input string tag, input logic [31:0] ea,
                               input logic we, input logic [31:0] wv);
    check({tag, " valid"}, {31'b0, valid}, 32'd1);
    check({tag, " addr"}, addr, ea);
    check({tag, " wb_en"}, {31'b0, wb_en}, {31'b0, we});
    if (we) check({tag, " wb_val"}, wb_val, wv);
  endtask

  task automatic t_reset();
    check("R1 valid after reset", {31'b0, valid}, 32'd0);
    check("R1 wb_en after reset", {31'b0, wb_en}, 32'd0);
  endtask

  task automatic t_imm_offset();
    issue(2'b00, 0, 32'h1000, 0, 12'h024, 0, 0, 0, 1, 0, 0);
    expect_result("R3 R6 imm add", 32'h1024, 0, 0);
    issue(2'b00, 0, 32'h1000, 0, 12'h018, 0, 0, 0, 0, 0, 0);
    expect_result("R3 R6 imm sub", 32'h0FE8, 0, 0);
    issue(2'b11, 0, 32'h2000, 0, 12'hFFF, 0, 0, 0, 1, 0, 0);
    expect_result("R3 reserved mode as offset", 32'h2FFF, 0, 0);
  endtask

  task automatic t_pre_post();
    issue(2'b01, 0, 32'h1000, 1, 0, 32'd3, 2'd0, 5'd2, 1, 0, 0);
    expect_result("R4 R7 pre lsl2", 32'h100C, 1, 32'h100C);
    issue(2'b10, 0, 32'h1008, 0, 12'h004, 0, 0, 0, 1, 0, 0);
    expect_result("R5 post imm", 32'h1008, 1, 32'h100C);
    issue(2'b10, 0, 32'h3000, 1, 0, 32'h10, 2'd1, 5'd2, 0, 0, 0);
    expect_result("R5 R7 post lsr sub", 32'h3000, 1, 32'h2FFC);
  endtask

  task automatic t_shift_kinds();
    logic [31:0] ix = 32'h8000_0010;
    for (int k = 0; k < 4; k++) begin
      logic [31:0] off = ref_shift(ix, 2'(k), 5'd4);
      issue(2'b00, 0, 32'h0100_0000, 1, 0, ix, 2'(k), 5'd4, 1, 0, 0);
      expect_result($sformatf("R7 shift kind %0d", k), 32'h0100_0000 + off, 0, 0);
    end
    check("R7 asr sign fill ref", ref_shift(ix, 2'd2, 5'd4), 32'hF800_0001);
    issue(2'b00, 0, 32'h0, 1, 0, 32'h0000_0055, 2'd3, 5'd0, 1, 0, 0);
    expect_result("R7 zero amount passthru", 32'h55, 0, 0);
    issue(2'b01, 0, 32'h0, 1, 0, 32'h1234_5678, 2'd3, 5'd31, 1, 0, 0);
    expect_result("R7 ror 31", 32'h2468_ACF0, 1, 32'h2468_ACF0);
  endtask

  task automatic t_pc_base();
    issue(2'b00, 1, 32'h0000_0100, 0, 12'h000, 0, 0, 0, 1, 0, 0);
    expect_result("R8 pc offset", 32'h0108, 0, 0);
    issue(2'b10, 1, 32'h0000_0FF0, 0, 12'h004, 0, 0, 0, 0, 0, 0);
    expect_result("R8 pc post", 32'h0FF8, 1, 32'h0FF4);
  endtask

  task automatic t_wrap();
    issue(2'b01, 0, 32'hFFFF_FFF8, 0, 12'h010, 0, 0, 0, 1, 0, 0);
    expect_result("R9 wrap up", 32'h0000_0008, 1, 32'h0000_0008);
    issue(2'b00, 0, 32'h0000_0004, 0, 12'h008, 0, 0, 0, 0, 0, 0);
    expect_result("R9 wrap down", 32'hFFFF_FFFC, 0, 0);
  endtask

  task automatic t_memory();
    issue(2'b00, 0, 32'h40, 0, 0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF);
    expect_result("R10 store a", 32'h40, 0, 0);
    issue(2'b10, 0, 32'h44, 0, 12'h4, 0, 0, 0, 1, 1, 32'h1234_5678);
    expect_result("R10 store b", 32'h44, 1, 32'h48);
    issue(2'b01, 0, 32'h48, 0, 12'h8, 0, 0, 0, 0, 0, 0);
    check("R10 load a", rd_data, 32'hDEAD_BEEF);
    issue(2'b00, 0, 32'h30, 1, 0, 32'd5, 2'd0, 5'd2, 1, 0, 0);
    check("R10 load b", rd_data, 32'h1234_5678);
    check("R10 load valid", {31'b0, valid}, 32'd1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R2 valid single pulse", {31'b0, valid}, 32'd0);
    check("R11 no wb without valid", {31'b0, wb_en}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_imm_offset();
    t_idle();
    t_pre_post();
    t_idle();
    t_shift_kinds();
    t_pc_base();
    t_wrap();
    t_memory();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule